// File: doc/BRIEF.md
# Byte-Lane Load/Store Bus Adapter

This unit turns one processor load or store into a single transfer on a 32-bit bus. The bus has four byte lanes, carries a word address and uses a request/acknowledge handshake. The processor side presents an operation, a size (byte, half-word or word), a byte address and store data, with a one-cycle request strobe. The unit drops the two low address bits and uses them with the size to select the byte lanes. For a store it places the data on those lanes. It then keeps the whole transfer steady until the target acknowledges.

On a load, the lanes that were read are moved down to bit 0 and zero-extended, and the result is returned with a one-cycle response strobe. An access that cannot fit inside one word is refused. In that case the unit raises an error pulse and starts no bus transfer. While a transfer is outstanding, the unit reports busy and ignores any further requests.

Top module: `bau_top`

## Requirements
- R1: During a bus transfer, `bus_addr` equals bits 31..2 of the accepted byte address. Lane i covers `bus_wdata`/`bus_rdata` bits 8i+7..8i.
- R2: The size encoding is 0 = byte, 1 = half-word, 2 or 3 = word. A word access at offset 0 drives `bus_be` = 4'b1111.
- R3: A half-word access drives `bus_be` = 4'b0011 at offset 0 and 4'b1100 at offset 2.
- R4: A byte access drives the single `bus_be` bit given by the address offset (0→0001, 1→0010, 2→0100, 3→1000). `bus_be` is never 0 during a transfer.
- R5: A transfer begins on the cycle after the request strobe. `bus_me` = 1 for the whole transfer, with `bus_rw` = 1 for a load (`req_store` = 0) and `bus_rw` = 0 for a store. When no transfer is active, `bus_me` = 0, `bus_be` = 0 and `bus_rw` = 1.
- R6: Address, enables, read/write and write data stay unchanged until `bus_ack` = 1 is seen at a clock edge. On the next cycle `bus_me` = 0 and `rsp_valid` = 1 for exactly one cycle.
- R7: For a store, the enabled lanes carry the store data shifted to the lane offset: the byte `req_wdata[7:0]` or the half-word `req_wdata[15:0]`.
- R8: For a load, `rsp_rdata` holds the selected lanes of `bus_rdata` moved to bit 0, with the upper bits zero. A store completes with `rsp_rdata` = 0.
- R9: A half-word at an odd offset, or a word at a nonzero offset, sets `misalign` = 1 for one cycle and starts no bus transfer and no response.
- R10: `busy` is 1 from the cycle after an accepted request until the cycle after the acknowledge. Requests that arrive while `busy` is 1, including in the acknowledge cycle, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| busy | output | 1 | Transfer outstanding |
| misalign | output | 1 | One-cycle misaligned-request pulse |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 32 | Zero-extended load result |
| bus_addr | output | 30 | Word address |
| bus_be | output | 4 | Byte-lane enables |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_me | output | 1 | Bus transfer enable |
| bus_wdata | output | 32 | Lane-steered write data |
| bus_ack | input | 1 | Target acknowledge |
| bus_rdata | input | 32 | Read data from target |

## Verification
A new request can arrive in the same cycle as the acknowledge that ends the current transfer. The unit must then finish the old transfer and drop the new request. The bench raises `req_valid` with a different address exactly when it returns `bus_ack`. It then checks that the response carries the old transfer's lanes and that `bus_me` stays low on the following cycles. A second overlap is a request made during a stretched wait. The bench checks that this request does not disturb the held address, enables and data.

// File: rtl/bau_pkg.sv
package bau_pkg;

    localparam int DATA_W  = 32;
    localparam int LANES   = DATA_W / 8;
    localparam int OFF_W   = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WRD2 = 2'd3
    } acc_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUS  = 1'b1
    } bau_state_e;

    typedef struct packed {
        logic             store;
        acc_size_e        size;
        logic [OFF_W-1:0] off;
        logic [LANES-1:0] be;
        logic [DATA_W-1:0] wdata;
    } xfer_t;

    function automatic logic [LANES-1:0] lane_mask(acc_size_e sz, logic [OFF_W-1:0] off);
        case (sz)
            SZ_BYTE: lane_mask = LANES'(1) << off;
            SZ_HALF: lane_mask = LANES'(3) << {off[OFF_W-1:1], 1'b0};
            default: lane_mask = '1;
        endcase
    endfunction

    function automatic logic is_misaligned(acc_size_e sz, logic [OFF_W-1:0] off);
        case (sz)
            SZ_BYTE: is_misaligned = 1'b0;
            SZ_HALF: is_misaligned = off[0];
            default: is_misaligned = (off != '0);
        endcase
    endfunction

endpackage

// File: rtl/bau_lane_decode.sv
module bau_lane_decode
    import bau_pkg::*;
(
    input  acc_size_e        size,
    input  logic [OFF_W-1:0] off,
    output logic [LANES-1:0] be,
    output logic             bad
);
    always_comb begin
        be  = lane_mask(size, off);
        bad = is_misaligned(size, off);
    end
endmodule

// File: rtl/bau_store_steer.sv
module bau_store_steer
    import bau_pkg::*;
(
    input  acc_size_e         size,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int HALVES = LANES / 2;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [7:0] src;
        always_comb begin
            case (size)
                SZ_BYTE: src = din[7:0];
                SZ_HALF: src = din[8*(i%2) +: 8];
                default: src = din[8*i +: 8];
            endcase
        end
        assign dout[8*i +: 8] = src;
    end

    logic unused_h;
    assign unused_h = (HALVES == 0);
endmodule

// File: rtl/bau_load_extract.sv
module bau_load_extract
    import bau_pkg::*;
(
    input  acc_size_e         size,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] shifted;
    assign shifted = din >> {off, 3'b000};

    for (genvar j = 0; j < LANES; j++) begin : g_out
        logic keep;
        always_comb begin
            if (j == 0)      keep = 1'b1;
            else if (j == 1) keep = (size != SZ_BYTE);
            else             keep = (size == SZ_WORD) || (size == SZ_WRD2);
        end
        assign dout[8*j +: 8] = keep ? shifted[8*j +: 8] : 8'h00;
    end
endmodule

// File: rtl/bau_ctrl.sv
module bau_ctrl
    import bau_pkg::*;
#(
    parameter int WADDR_W = 30
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_bad,
    input  xfer_t              req_x,
    input  logic [WADDR_W-1:0] req_waddr,
    input  logic               bus_ack,
    input  logic [DATA_W-1:0]  load_val,
    output acc_size_e          held_size,
    output logic [OFF_W-1:0]   held_off,
    output logic               busy,
    output logic               misalign,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic [WADDR_W-1:0] bus_addr,
    output logic [LANES-1:0]   bus_be,
    output logic               bus_rw,
    output logic               bus_me,
    output logic [DATA_W-1:0]  bus_wdata
);
    bau_state_e state;
    xfer_t      held;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            held      <= '0;
            bus_addr  <= '0;
            bus_me    <= 1'b0;
            misalign  <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            misalign  <= 1'b0;
            rsp_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (req_bad) begin
                            misalign <= 1'b1;
                        end else begin
                            state    <= ST_BUS;
                            held     <= req_x;
                            bus_addr <= req_waddr;
                            bus_me   <= 1'b1;
                        end
                    end
                end
                default: begin
                    if (bus_ack) begin
                        state     <= ST_IDLE;
                        bus_me    <= 1'b0;
                        rsp_valid <= 1'b1;
                        rsp_rdata <= held.store ? '0 : load_val;
                        held.be   <= '0;
                        held.store <= 1'b0;
                    end
                end
            endcase
        end
    end

    assign busy      = (state == ST_BUS);
    assign bus_be    = held.be;
    assign bus_rw    = ~held.store;
    assign bus_wdata = held.wdata;
    assign held_size = held.size;
    assign held_off  = held.off;
endmodule

// File: rtl/bau_top.sv
module bau_top
    import bau_pkg::*;
#(
    parameter int ADDR_W = 32,
    localparam int WADDR_W = ADDR_W - OFF_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_store,
    input  logic [1:0]         req_size,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               busy,
    output logic               misalign,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic [WADDR_W-1:0] bus_addr,
    output logic [LANES-1:0]   bus_be,
    output logic               bus_rw,
    output logic               bus_me,
    output logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_ack,
    input  logic [DATA_W-1:0]  bus_rdata
);
    acc_size_e         sz_in;
    logic [OFF_W-1:0]  off_in;
    logic [LANES-1:0]  be_in;
    logic              bad_in;
    logic [DATA_W-1:0] steered;
    xfer_t             x_in;
    acc_size_e         sz_q;
    logic [OFF_W-1:0]  off_q;
    logic [DATA_W-1:0] load_val;

    assign sz_in  = acc_size_e'(req_size);
    assign off_in = req_addr[OFF_W-1:0];

    bau_lane_decode dec_i (.size(sz_in), .off(off_in), .be(be_in), .bad(bad_in));

    bau_store_steer steer_i (.size(sz_in), .din(req_wdata), .dout(steered));

    always_comb begin
        x_in.store = req_store;
        x_in.size  = sz_in;
        x_in.off   = off_in;
        x_in.be    = be_in;
        x_in.wdata = steered;
    end

    bau_load_extract ext_i (.size(sz_q), .off(off_q), .din(bus_rdata), .dout(load_val));

    bau_ctrl #(.WADDR_W(WADDR_W)) ctrl_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_bad(bad_in), .req_x(x_in),
        .req_waddr(req_addr[ADDR_W-1:OFF_W]),
        .bus_ack(bus_ack), .load_val(load_val),
        .held_size(sz_q), .held_off(off_q),
        .busy(busy), .misalign(misalign),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_rw(bus_rw),
        .bus_me(bus_me), .bus_wdata(bus_wdata)
    );
endmodule

// File: rtl/bau_checker.sv
module bau_checker #(
    parameter int WADDR_W = 30
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               busy,
    input logic               misalign,
    input logic               rsp_valid,
    input logic [WADDR_W-1:0] bus_addr,
    input logic [3:0]         bus_be,
    input logic               bus_rw,
    input logic               bus_me,
    input logic [31:0]        bus_wdata,
    input logic               bus_ack
);
    assert_hold_until_ack_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_me && !bus_ack) |=> (bus_me && $stable(bus_addr) && $stable(bus_be)
                                  && $stable(bus_rw) && $stable(bus_wdata)));

    assert_release_after_ack_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_me && bus_ack) |=> (!bus_me && rsp_valid));

    assert_be_legal_R4: assert property (@(posedge clk) disable iff (rst)
        bus_me |-> ($countones(bus_be) == 1 || $countones(bus_be) == 2 || $countones(bus_be) == 4));

    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        !bus_me |-> (bus_be == 4'b0000 && bus_rw));

    assert_no_bus_on_misalign_R9: assert property (@(posedge clk) disable iff (rst)
        misalign |-> (!bus_me && !rsp_valid));

    assert_start_needs_request_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_me) |-> ($past(req_valid) && busy));

    assert_busy_holds_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && !bus_ack) |=> busy);
endmodule

bind bau_top bau_checker #(.WADDR_W(WADDR_W)) chk_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .busy(busy),
    .misalign(misalign), .rsp_valid(rsp_valid), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_rw(bus_rw), .bus_me(bus_me),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack)
);

// File: tb/bau_tb.sv
module bau_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_store;
    logic [1:0]  req_size;
    logic [31:0] req_addr, req_wdata;
    logic        busy, misalign, rsp_valid;
    logic [31:0] rsp_rdata;
    logic [29:0] bus_addr;
    logic [3:0]  bus_be;
    logic        bus_rw, bus_me;
    logic [31:0] bus_wdata;
    logic        bus_ack;
    logic [31:0] bus_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bau_top dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .misalign(misalign), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_rw(bus_rw), .bus_me(bus_me),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_be(input logic [1:0] sz, input logic [1:0] off);
        if (sz == 2'd0) return 4'b0001 << off;
        if (sz == 2'd1) return (off == 2'd0) ? 4'b0011 : 4'b1100;
        return 4'b1111;
    endfunction

    function automatic logic [31:0] lane_bits(input logic [3:0] be);
        logic [31:0] m;
        for (int i = 0; i < 4; i++) m[8*i +: 8] = be[i] ? 8'hFF : 8'h00;
        return m;
    endfunction

    function automatic logic [31:0] size_mask(input logic [1:0] sz);
        if (sz == 2'd0) return 32'h0000_00FF;
        if (sz == 2'd1) return 32'h0000_FFFF;
        return 32'hFFFF_FFFF;
    endfunction

    // Full transfer; optional stray request during the wait and in the ack cycle
    task automatic do_access(input bit st, input logic [1:0] sz, input logic [31:0] a,
                             input logic [31:0] wd, input int dly, input logic [31:0] rd,
                             input bit stray);
        logic [3:0]  be  = exp_be(sz, a[1:0]);
        logic [31:0] m   = lane_bits(be);
        logic [31:0] ew  = (wd & size_mask(sz)) << (8 * a[1:0]);
        logic [31:0] er  = st ? 32'h0 : ((rd >> (8 * a[1:0])) & size_mask(sz));
        @(negedge clk);
        req_valid = 1'b1; req_store = st; req_size = sz; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check(bus_me && busy, "R5/R10 transfer start", {30'h0, bus_me, busy}, 32'h3);
        check(bus_addr == a[31:2], "R1 word address", {2'b0, bus_addr}, {2'b0, a[31:2]});
        check(bus_be == be, "R2/R3/R4 byte enables", {28'h0, bus_be}, {28'h0, be});
        check(bus_rw == !st, "R5 read/write line", {31'h0, bus_rw}, {31'h0, !st});
        if (st) check((bus_wdata & m) == ew, "R7 store lanes", bus_wdata & m, ew);
        for (int k = 0; k < dly; k++) begin
            if (stray) begin
                req_valid = 1'b1; req_addr = a ^ 32'h0000_0F04; req_size = 2'd2;
                req_store = !st; req_wdata = ~wd;
            end
            @(negedge clk);
            req_valid = 1'b0;
            check(bus_me && bus_addr == a[31:2] && bus_be == be && bus_rw == !st,
                  "R6/R10 hold while waiting", {2'b0, bus_addr}, {2'b0, a[31:2]});
            if (st) check((bus_wdata & m) == ew, "R6 store data held", bus_wdata & m, ew);
            check(!rsp_valid, "R6 no early response", {31'h0, rsp_valid}, 32'h0);
        end
        bus_ack = 1'b1; bus_rdata = rd;
        if (stray) begin
            req_valid = 1'b1; req_addr = 32'h0000_2000; req_size = 2'd0; req_store = 1'b0;
        end
        @(negedge clk);
        bus_ack = 1'b0; bus_rdata = 32'hDEAD_BEEF; req_valid = 1'b0;
        check(!bus_me && !busy && rsp_valid, "R6/R10 completion",
              {29'h0, bus_me, busy, rsp_valid}, 32'h1);
        check(rsp_rdata == er, "R8 response data", rsp_rdata, er);
        @(negedge clk);
        check(!rsp_valid && !bus_me && bus_be == 4'b0 && bus_rw, "R5/R6/R10 idle after completion",
              {26'h0, rsp_valid, bus_me, bus_be}, 32'h0);
    endtask

    task automatic t_reset();
        check(!busy && !bus_me && !misalign && !rsp_valid && bus_be == 4'b0 && bus_rw,
              "R5 reset state", {26'h0, busy, bus_me, bus_be}, 32'h0);
    endtask

    task automatic t_word();
        do_access(1'b0, 2'd2, 32'h0000_1000, 32'h0, 0, 32'hCAFE_F00D, 1'b0);
        do_access(1'b1, 2'd3, 32'h0030_0000, 32'hFABF_ADAD, 1, 32'h0, 1'b0);
    endtask

    task automatic t_half();
        do_access(1'b0, 2'd1, 32'h0020_0000, 32'h0, 0, 32'h8765_4321, 1'b0);
        do_access(1'b0, 2'd1, 32'h0020_0002, 32'h0, 2, 32'h8765_4321, 1'b0);
        do_access(1'b1, 2'd1, 32'h0020_0002, 32'h1234_ABCD, 0, 32'h0, 1'b0);
        do_access(1'b1, 2'd1, 32'h0020_0000, 32'h0000_5A5A, 0, 32'h0, 1'b0);
    endtask

    task automatic t_byte();
        for (int o = 0; o < 4; o++) begin
            do_access(1'b0, 2'd0, 32'h0000_0010 + o, 32'h0, 0, 32'hF1E2_D3C4, 1'b0);
            do_access(1'b1, 2'd0, 32'h0000_0018 + o, 32'hFFFF_FF00 | (8'h30 + o), 1, 32'h0, 1'b0);
        end
    endtask

    task automatic t_misalign(input logic [1:0] sz, input logic [31:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_store = 1'b1; req_size = sz; req_addr = a; req_wdata = 32'h1111_2222;
        @(negedge clk);
        req_valid = 1'b0;
        check(misalign && !bus_me && !busy && !rsp_valid, "R9 misaligned refused",
              {28'h0, misalign, bus_me, busy, rsp_valid}, 32'h8);
        @(negedge clk);
        check(!misalign && !bus_me && !rsp_valid, "R9 single pulse, no transfer",
              {29'h0, misalign, bus_me, rsp_valid}, 32'h0);
    endtask

    task automatic t_overlap();
        do_access(1'b0, 2'd0, 32'h0000_4003, 32'h0, 3, 32'hAB00_0000, 1'b1);
        @(negedge clk);
        check(!bus_me && !busy, "R10 ack-cycle request dropped", {30'h0, bus_me, busy}, 32'h0);
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_store = 1'b0; req_size = 2'd0;
        req_addr = '0; req_wdata = '0; bus_ack = 1'b0; bus_rdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_word();
        t_half();
        t_byte();
        t_misalign(2'd1, 32'h0000_0101);
        t_misalign(2'd1, 32'h0000_0103);
        t_misalign(2'd2, 32'h0000_0102);
        t_misalign(2'd3, 32'h0000_0101);
        t_overlap();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule